// File: doc/BRIEF.md
# Link Training Sequencer

This block runs the two-phase link training handshake with a display sink over a register-access port. On `start` it takes a snapshot of the lane count, the link rate, whether the sink can use the third training pattern, and a training interval given in clock cycles. It then programs the sink, runs the clock-recovery phase and the channel-equalization phase, and finally clears the training pattern. A one-cycle `done` pulse reports the result: a pass bit and a code that names the phase that failed. The electrical side of the auxiliary channel, the PHY and rate fallback are handled elsewhere. If a phase fails, training stops.

Each request on the access port carries an address, a direction, a length of up to six bytes and up to four write bytes. Byte 0 of the write data goes to the lowest address. The request stays up until the sink answers with `acc_ack`, or with `acc_err` to signal an error. Read data comes back on `acc_rdata` in the ack cycle, with the lowest address in bits 7:0.

The controller is one FSM with these states:

- `ST_IDLE` moves to `ST_RATE` on `start`.
- `ST_RATE` moves to `ST_CLEAR`.
- `ST_CLEAR` moves to `ST_GAP`.
- `ST_GAP` waits one interval. It then moves to `ST_POWER` at the start of training, to phase 2 entry after phase 1, or to `ST_FINISH` after the final clear.
- `ST_POWER` moves to `ST_DRIVE`, or to `ST_PATTERN` if the levels are illegal.
- `ST_DRIVE` moves to `ST_PATTERN` when a phase is being entered, and to `ST_SETTLE` otherwise.
- `ST_PATTERN` moves to `ST_SETTLE`.
- `ST_SETTLE` waits, then moves to `ST_POLL`.
- `ST_POLL` moves to `ST_JUDGE`.
- `ST_JUDGE` moves to `ST_CLEAR` on success or failure. Otherwise it moves to `ST_DRIVE`, or to `ST_SETTLE` when the new levels are illegal.
- `ST_FINISH` moves to `ST_IDLE`.
- Any access state jumps to `ST_FINISH` on an error or a timeout.

Top module: `dp_link_trainer`

## Requirements
- R1: On start, the block performs these steps in order:
  - it writes 2 bytes to address 0x100 (byte 0 is the link rate, byte 1 is the effective lane count);
  - it writes 0x00 to 0x102;
  - it waits at least one interval;
  - it writes 0x01 to 0x600.
  
  A `lane_cfg` of 1 or 2 selects that many lanes. Any other value selects 4.
- R2: Phase 1 writes the drive setting and then 0x21 to 0x102. Before each poll it waits at least ten intervals. A poll is a 6-byte read from 0x202. Status byte k arrives in `acc_rdata` bits 8k+7:8k.
- R3: Clock recovery is complete when bit 4n of the 16-bit lane status {byte1, byte0} is set for every active lane n. Status bits of inactive lanes are ignored.
- R4: Equalization is complete only when two conditions hold: bit 0 of status byte 2 (the alignment flag) is set, and bits 4n+2:4n are all set for every active lane n.
- R5: After an unsuccessful poll, the new swing becomes the maximum of the requested swing over the active lanes, and the new pre-emphasis becomes the maximum of the requested pre-emphasis over the active lanes. In the 16-bit word {byte5, byte4}, lane n requests swing in bits 4n+1:4n and pre-emphasis in bits 4n+3:4n+2. Both levels start at 0.
- R6: A drive update is written only when swing plus pre-emphasis is at most 3. The update is a 4-byte write to 0x103 with the same byte in every lane. Each byte holds swing in bits 1:0 and pre-emphasis in bits 4:3. Bit 2 is set when swing equals 3, and bit 5 is set when pre-emphasis equals 3.
- R7: Phase 1 fails with code 1 when either of these happens:
  - a poll is not successful while the swing already equals 3;
  - the swing has been unchanged for 5 consecutive unsuccessful polls. This count restarts whenever the swing changes.
- R8: Phase 2 first applies the drive setting. It then writes 0x23 to 0x102 if the third pattern is supported, and 0x22 if not. It waits at least one interval before each poll. It fails with code 2 on its sixth unsuccessful poll.
- R9: Between the phases, and at the end of both passing and failing training, the block writes 0x00 to 0x102 and then waits one interval.
- R10: An `acc_err` response, or a request left without an answer for `ACK_TIMEOUT` cycles, ends training at once with code 3. No further request follows.
- R11: `done` is high for exactly one cycle. In that cycle, `pass` = 1 goes with code 0. `start` has no effect while `busy` is high.
- R12: A request keeps its address and data stable until it is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training (ignored while busy) |
| lane_cfg | input | 3 | Requested lane count: 1, 2, else 4 |
| link_rate | input | 8 | Link rate byte written to the sink |
| tps3_ok | input | 1 | Third training pattern supported |
| interval_cycles | input | INTERVAL_W | Training interval in clock cycles |
| acc_req | output | 1 | Access request pending |
| acc_we | output | 1 | 1 for write, 0 for read |
| acc_addr | output | 16 | Sink register address |
| acc_len | output | 3 | Byte count of the access |
| acc_wdata | output | 32 | Write bytes, byte 0 in bits 7:0 |
| acc_ack | input | 1 | Access completed |
| acc_err | input | 1 | Access completed with error |
| acc_rdata | input | 48 | Read bytes, valid with acc_ack |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Training result, valid with done |
| fail_code | output | 2 | 0 none, 1 clock recovery, 2 equalization, 3 access |
| busy | output | 1 | Training in progress |

## Verification
The hardest behaviour to reach is the phase 1 stall counter. It only runs out after five unsuccessful polls in a row with no change in swing. It also has to be shown restarting after the swing rises and then drops back, and an illegal level pair has to be skipped along the way. The bench reaches this by scripting a sequence of sink status replies for each run. One run makes an early poll request an illegal swing/pre-emphasis pair, which is adopted but not written. Later replies pull the swing back to zero, so the counter restarts before it runs out. The bench model replays the same replies through its own copy of the training rules to predict every access and the final code.

// File: rtl/dplt_pkg.sv
package dplt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RATE,
        ST_CLEAR,
        ST_GAP,
        ST_POWER,
        ST_DRIVE,
        ST_PATTERN,
        ST_SETTLE,
        ST_POLL,
        ST_JUDGE,
        ST_FINISH
    } lt_state_e;

    typedef enum logic [1:0] {
        CTX_INIT,
        CTX_MID,
        CTX_END
    } clr_ctx_e;

    localparam logic [1:0] FAIL_NONE   = 2'd0;
    localparam logic [1:0] FAIL_CR     = 2'd1;
    localparam logic [1:0] FAIL_EQ     = 2'd2;
    localparam logic [1:0] FAIL_ACCESS = 2'd3;

    localparam logic [15:0] ADDR_RATE    = 16'h0100;
    localparam logic [15:0] ADDR_PATTERN = 16'h0102;
    localparam logic [15:0] ADDR_DRIVE   = 16'h0103;
    localparam logic [15:0] ADDR_STATUS  = 16'h0202;
    localparam logic [15:0] ADDR_POWER   = 16'h0600;

    localparam int MAX_LANES    = 4;
    localparam int CR_STALL_LIM = 5;
    localparam int EQ_POLL_LIM  = 5;

    localparam logic [7:0] PAT_PHASE1 = 8'h21;
    localparam logic [7:0] PAT_FLAG   = 8'h20;

endpackage

// File: rtl/dplt_countdown.sv
module dplt_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dplt_lane_eval.sv
module dplt_lane_eval #(
    parameter int LANES = 4
) (
    input  logic [2:0]         lanes_n,
    input  logic [4*LANES-1:0] lane_stat,
    input  logic               aligned,
    input  logic [4*LANES-1:0] adjust,
    output logic               cr_ok,
    output logic               eq_ok,
    output logic [1:0]         max_sw,
    output logic [1:0]         max_pe
);
    logic [LANES-1:0] active;
    logic [LANES-1:0] cr_lane;
    logic [LANES-1:0] eq_lane;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign active[g]  = (int'(lanes_n) > g);
        assign cr_lane[g] = !active[g] || lane_stat[4*g];
        assign eq_lane[g] = !active[g] || (&lane_stat[4*g +: 3]);
    end

    assign cr_ok = &cr_lane;
    assign eq_ok = aligned && (&eq_lane);

    always_comb begin
        max_sw = 2'd0;
        max_pe = 2'd0;
        for (int i = 0; i < LANES; i++) begin
            if (active[i]) begin
                if (adjust[4*i +: 2] > max_sw)
                    max_sw = adjust[4*i +: 2];
                if (adjust[4*i+2 +: 2] > max_pe)
                    max_pe = adjust[4*i+2 +: 2];
            end
        end
    end
endmodule

// File: rtl/dplt_drive_enc.sv
module dplt_drive_enc (
    input  logic [1:0] sw,
    input  logic [1:0] pe,
    output logic       legal,
    output logic [7:0] code
);
    always_comb begin
        legal = ({1'b0, sw} + {1'b0, pe}) <= 3'd3;
        code  = {2'b00, (pe == 2'd3), pe, (sw == 2'd3), sw};
    end
endmodule

// File: rtl/dp_link_trainer.sv
module dp_link_trainer
    import dplt_pkg::*;
#(
    parameter int INTERVAL_W  = 16,
    parameter int ACK_TIMEOUT = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2:0]            lane_cfg,
    input  logic [7:0]            link_rate,
    input  logic                  tps3_ok,
    input  logic [INTERVAL_W-1:0] interval_cycles,
    output logic                  acc_req,
    output logic                  acc_we,
    output logic [15:0]           acc_addr,
    output logic [2:0]            acc_len,
    output logic [31:0]           acc_wdata,
    input  logic                  acc_ack,
    input  logic                  acc_err,
    input  logic [47:0]           acc_rdata,
    output logic                  done,
    output logic                  pass,
    output logic [1:0]            fail_code,
    output logic                  busy
);
    localparam int WAIT_W = INTERVAL_W + 4;
    localparam int TO_W   = $clog2(ACK_TIMEOUT + 1);

    lt_state_e st, nxt;
    clr_ctx_e  ctx;

    logic                  phase2;
    logic                  entering;
    logic [1:0]            sw, pe, old_sw;
    logic [2:0]            tries;
    logic [2:0]            lanes_q;
    logic [7:0]            rate_q;
    logic                  tps3_q;
    logic [INTERVAL_W-1:0] intv_q;
    logic [47:0]           stat_q;
    logic                  pass_q;
    logic [1:0]            code_q;

    // Evaluation of the captured status
    logic       cr_ok, eq_ok;
    logic [1:0] req_sw, req_pe;

    dplt_lane_eval #(.LANES(MAX_LANES)) u_eval (
        .lanes_n  (lanes_q),
        .lane_stat(stat_q[15:0]),
        .aligned  (stat_q[16]),
        .adjust   (stat_q[47:32]),
        .cr_ok    (cr_ok),
        .eq_ok    (eq_ok),
        .max_sw   (req_sw),
        .max_pe   (req_pe)
    );

    // Drive encoding for present levels and for newly requested levels
    logic       cur_legal, new_legal;
    logic [7:0] cur_code, new_code;

    dplt_drive_enc u_enc_cur (.sw(sw),     .pe(pe),     .legal(cur_legal), .code(cur_code));
    dplt_drive_enc u_enc_new (.sw(req_sw), .pe(req_pe), .legal(new_legal), .code(new_code));

    // Wait timer (gap and settle) and access timeout
    logic              wait_load, wait_zero;
    logic [WAIT_W-1:0] wait_val;
    logic              to_load, to_zero;
    logic              timeout;
    logic              is_access;
    logic              acc_fin_ok, acc_fin_bad;

    always_comb begin
        if (nxt == ST_SETTLE && phase2 == 1'b0 && st != ST_CLEAR)
            wait_val = WAIT_W'({intv_q, 3'b000}) + WAIT_W'({intv_q, 1'b0});
        else
            wait_val = WAIT_W'(intv_q);
    end

    assign wait_load = ((nxt == ST_SETTLE) && (st != ST_SETTLE)) ||
                       ((nxt == ST_GAP) && (st != ST_GAP));

    dplt_countdown #(.W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(wait_load), .value(wait_val), .zero(wait_zero)
    );

    assign to_load = !acc_req || acc_ack || acc_err;

    dplt_countdown #(.W(TO_W)) u_timeout (
        .clk(clk), .rst_n(rst_n), .load(to_load), .value(TO_W'(ACK_TIMEOUT)), .zero(to_zero)
    );

    assign is_access = (st == ST_RATE) || (st == ST_CLEAR) || (st == ST_POWER) ||
                       (st == ST_DRIVE) || (st == ST_PATTERN) || (st == ST_POLL);
    assign timeout     = is_access && to_zero;
    assign acc_fin_bad = is_access && (acc_err || timeout);
    assign acc_fin_ok  = is_access && acc_ack && !acc_err;

    // Judgement of a poll
    logic       stuck;
    logic [2:0] tries_inc;
    logic       j_ok, j_fail;
    logic [2:0] j_tries;

    always_comb begin
        stuck     = (sw == old_sw);
        tries_inc = tries + 3'd1;
        j_ok      = phase2 ? eq_ok : cr_ok;
        if (phase2) begin
            j_fail  = !j_ok && (int'(tries_inc) > EQ_POLL_LIM);
            j_tries = tries_inc;
        end else begin
            j_fail  = !j_ok && ((sw == 2'd3) || (stuck && int'(tries_inc) >= CR_STALL_LIM));
            j_tries = stuck ? tries_inc : 3'd0;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:    if (start) nxt = ST_RATE;
            ST_RATE:    if (acc_fin_bad) nxt = ST_FINISH; else if (acc_fin_ok) nxt = ST_CLEAR;
            ST_CLEAR:   if (acc_fin_bad) nxt = ST_FINISH; else if (acc_fin_ok) nxt = ST_GAP;
            ST_GAP: begin
                if (wait_zero) begin
                    unique case (ctx)
                        CTX_INIT: nxt = ST_POWER;
                        CTX_MID:  nxt = cur_legal ? ST_DRIVE : ST_PATTERN;
                        default:  nxt = ST_FINISH;
                    endcase
                end
            end
            ST_POWER: begin
                if (acc_fin_bad)     nxt = ST_FINISH;
                else if (acc_fin_ok) nxt = cur_legal ? ST_DRIVE : ST_PATTERN;
            end
            ST_DRIVE: begin
                if (acc_fin_bad)     nxt = ST_FINISH;
                else if (acc_fin_ok) nxt = entering ? ST_PATTERN : ST_SETTLE;
            end
            ST_PATTERN: if (acc_fin_bad) nxt = ST_FINISH; else if (acc_fin_ok) nxt = ST_SETTLE;
            ST_SETTLE:  if (wait_zero) nxt = ST_POLL;
            ST_POLL:    if (acc_fin_bad) nxt = ST_FINISH; else if (acc_fin_ok) nxt = ST_JUDGE;
            ST_JUDGE: begin
                if (j_ok || j_fail) nxt = ST_CLEAR;
                else                nxt = new_legal ? ST_DRIVE : ST_SETTLE;
            end
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            ctx      <= CTX_INIT;
            phase2   <= 1'b0;
            entering <= 1'b0;
            sw       <= 2'd0;
            pe       <= 2'd0;
            old_sw   <= 2'd0;
            tries    <= 3'd0;
            lanes_q  <= 3'd4;
            rate_q   <= 8'd0;
            tps3_q   <= 1'b0;
            intv_q   <= '0;
            stat_q   <= '0;
            pass_q   <= 1'b0;
            code_q   <= FAIL_NONE;
        end else begin
            st <= nxt;
            if (acc_fin_bad) begin
                pass_q <= 1'b0;
                code_q <= FAIL_ACCESS;
            end
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        lanes_q  <= (lane_cfg == 3'd1) ? 3'd1 : (lane_cfg == 3'd2) ? 3'd2 : 3'd4;
                        rate_q   <= link_rate;
                        tps3_q   <= tps3_ok;
                        intv_q   <= interval_cycles;
                        ctx      <= CTX_INIT;
                        phase2   <= 1'b0;
                        entering <= 1'b1;
                        sw       <= 2'd0;
                        pe       <= 2'd0;
                        old_sw   <= 2'd0;
                        tries    <= 3'd0;
                        pass_q   <= 1'b0;
                        code_q   <= FAIL_NONE;
                    end
                end
                ST_GAP: if (wait_zero && ctx == CTX_MID) entering <= 1'b1;
                ST_PATTERN: if (acc_fin_ok) entering <= 1'b0;
                ST_POLL: if (acc_fin_ok) stat_q <= acc_rdata;
                ST_JUDGE: begin
                    if (j_ok) begin
                        if (!phase2) begin
                            phase2 <= 1'b1;
                            tries  <= 3'd0;
                            ctx    <= CTX_MID;
                        end else begin
                            ctx    <= CTX_END;
                            pass_q <= 1'b1;
                            code_q <= FAIL_NONE;
                        end
                    end else if (j_fail) begin
                        ctx    <= CTX_END;
                        pass_q <= 1'b0;
                        code_q <= phase2 ? FAIL_EQ : FAIL_CR;
                    end else begin
                        tries <= j_tries;
                        if (!phase2 && !stuck)
                            old_sw <= sw;
                        sw       <= req_sw;
                        pe       <= req_pe;
                        entering <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        acc_req   = is_access;
        acc_we    = (st != ST_POLL);
        acc_addr  = 16'h0000;
        acc_len   = 3'd0;
        acc_wdata = 32'h0;
        unique case (st)
            ST_RATE: begin
                acc_addr  = ADDR_RATE;
                acc_len   = 3'd2;
                acc_wdata = {16'h0, 5'd0, lanes_q, rate_q};
            end
            ST_CLEAR: begin
                acc_addr = ADDR_PATTERN;
                acc_len  = 3'd1;
            end
            ST_POWER: begin
                acc_addr  = ADDR_POWER;
                acc_len   = 3'd1;
                acc_wdata = 32'h1;
            end
            ST_DRIVE: begin
                acc_addr  = ADDR_DRIVE;
                acc_len   = 3'd4;
                acc_wdata = {4{cur_code}};
            end
            ST_PATTERN: begin
                acc_addr  = ADDR_PATTERN;
                acc_len   = 3'd1;
                acc_wdata = {24'h0, phase2 ? (PAT_FLAG | (tps3_q ? 8'h03 : 8'h02)) : PAT_PHASE1};
            end
            ST_POLL: begin
                acc_addr = ADDR_STATUS;
                acc_len  = 3'd6;
            end
            default: ;
        endcase
        done      = (st == ST_FINISH);
        busy      = (st != ST_IDLE);
        pass      = pass_q;
        fail_code = code_q;
    end
endmodule

// File: rtl/dplt_checker.sv
module dplt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_req,
    input logic        acc_we,
    input logic [15:0] acc_addr,
    input logic [2:0]  acc_len,
    input logic [31:0] acc_wdata,
    input logic        acc_ack,
    input logic        acc_err,
    input logic        done,
    input logic        pass,
    input logic [1:0]  fail_code,
    input logic        busy
);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_pass_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (fail_code == 2'd0));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_ack && !acc_err) |=>
            ((acc_req && $stable(acc_addr) && $stable(acc_wdata)) || done));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !acc_req);

    assert_drive_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_we && acc_addr == 16'h0103) |->
            (({1'b0, acc_wdata[1:0]} + {1'b0, acc_wdata[4:3]}) <= 3'd3 &&
             acc_wdata[31:24] == acc_wdata[7:0] && acc_wdata[23:16] == acc_wdata[7:0] &&
             acc_wdata[15:8] == acc_wdata[7:0] && acc_len == 3'd4));

    assert_pattern_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_we && acc_addr == 16'h0102) |->
            (acc_wdata[7:0] == 8'h00 || acc_wdata[7:0] == 8'h21 ||
             acc_wdata[7:0] == 8'h22 || acc_wdata[7:0] == 8'h23));

    assert_status_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_we) |-> (acc_addr == 16'h0202 && acc_len == 3'd6));
endmodule

bind dp_link_trainer dplt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_req  (acc_req),
    .acc_we   (acc_we),
    .acc_addr (acc_addr),
    .acc_len  (acc_len),
    .acc_wdata(acc_wdata),
    .acc_ack  (acc_ack),
    .acc_err  (acc_err),
    .done     (done),
    .pass     (pass),
    .fail_code(fail_code),
    .busy     (busy)
);

// File: tb/dp_link_trainer_test.sv
module dp_link_trainer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  lane_cfg = 3'd4;
    logic [7:0]  link_rate = 8'd0;
    logic        tps3_ok = 1'b0;
    logic [15:0] interval_cycles = 16'd1;
    logic        acc_req, acc_we;
    logic [15:0] acc_addr;
    logic [2:0]  acc_len;
    logic [31:0] acc_wdata;
    logic        acc_ack = 1'b0;
    logic        acc_err = 1'b0;
    logic [47:0] acc_rdata = '0;
    logic        done, pass, busy;
    logic [1:0]  fail_code;

    dp_link_trainer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_cfg(lane_cfg),
        .link_rate(link_rate), .tps3_ok(tps3_ok), .interval_cycles(interval_cycles),
        .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr), .acc_len(acc_len),
        .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_err(acc_err), .acc_rdata(acc_rdata),
        .done(done), .pass(pass), .fail_code(fail_code), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Expected transactions of the reference model
    bit          e_we[$];
    int          e_addr[$];
    int          e_len[$];
    logic [31:0] e_data[$];
    int          e_wait[$];
    string       e_tag[$];
    logic [47:0] stat_in[$];
    int          pend_wait;
    int          exp_code;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic add(input bit we, input int addr, input int len, input logic [31:0] data, input string tag);
        e_we.push_back(we); e_addr.push_back(addr); e_len.push_back(len);
        e_data.push_back(data); e_wait.push_back(pend_wait); e_tag.push_back(tag);
        pend_wait = 0;
    endtask

    function automatic logic [47:0] stat_at(input int k);
        if (k < stat_in.size()) return stat_in[k];
        return 48'h0;
    endfunction

    function automatic logic [47:0] mk(input logic [15:0] lanes, input bit align, input logic [15:0] adj);
        return {adj, 8'h00, 7'h00, align, lanes};
    endfunction

    function automatic logic [31:0] drive_word(input int v, input int p);
        int b;
        b = v | ((v == 3) ? 4 : 0) | (p << 3) | ((p == 3) ? 32 : 0);
        return 32'(b) * 32'h01010101;
    endfunction

    task automatic adopt(input logic [47:0] s, input int nl, inout int v, inout int p);
        v = 0; p = 0;
        for (int i = 0; i < nl; i++) begin
            if (int'(s[32+4*i +: 2]) > v) v = int'(s[32+4*i +: 2]);
            if (int'(s[34+4*i +: 2]) > p) p = int'(s[34+4*i +: 2]);
        end
    endtask

    // Behavioural model of the training rules (R1..R9)
    task automatic model(input int lanes, input int rate, input int tps3, input int intv);
        int nl, v, p, oldv, tries, k;
        bit ok;
        logic [47:0] s;
        e_we.delete(); e_addr.delete(); e_len.delete(); e_data.delete(); e_wait.delete(); e_tag.delete();
        pend_wait = 0;
        nl = (lanes == 1) ? 1 : (lanes == 2) ? 2 : 4;
        add(1, 'h100, 2, 32'((nl << 8) | rate), "R1");
        add(1, 'h102, 1, 0, "R1");
        pend_wait = intv;
        add(1, 'h600, 1, 1, "R1");
        v = 0; p = 0; oldv = 0; tries = 0; k = 0; exp_code = 0;
        if (v + p <= 3) add(1, 'h103, 4, drive_word(v, p), "R6");
        add(1, 'h102, 1, 'h21, "R2");
        while (1) begin
            pend_wait = 10 * intv;
            add(0, 'h202, 6, 0, "R2");
            s = stat_at(k); k++;
            ok = 1;
            for (int i = 0; i < nl; i++) if (!s[4*i]) ok = 0;
            if (ok) break;
            if (v == 3) begin exp_code = 1; break; end
            if (v == oldv) begin
                tries++;
                if (tries >= 5) begin exp_code = 1; break; end
            end else begin
                tries = 0; oldv = v;
            end
            adopt(s, nl, v, p);
            if (v + p <= 3) add(1, 'h103, 4, drive_word(v, p), "R5");
        end
        add(1, 'h102, 1, 0, "R9");
        pend_wait = intv;
        if (exp_code == 0) begin
            if (v + p <= 3) add(1, 'h103, 4, drive_word(v, p), "R6");
            add(1, 'h102, 1, tps3 ? 'h23 : 'h22, "R8");
            tries = 0;
            while (1) begin
                pend_wait = intv;
                add(0, 'h202, 6, 0, "R8");
                s = stat_at(k); k++;
                ok = s[16];
                for (int i = 0; i < nl; i++) if (s[4*i +: 3] != 3'b111) ok = 0;
                if (ok) break;
                tries++;
                if (tries > 5) begin exp_code = 2; break; end
                adopt(s, nl, v, p);
                if (v + p <= 3) add(1, 'h103, 4, drive_word(v, p), "R5");
            end
            add(1, 'h102, 1, 0, "R9");
        end
    endtask

    // kind: 0 normal, 1 error response at index abort_idx, 2 no answer at abort_idx
    task automatic run(input string name, input int lanes, input int rate, input int tps3, input int intv,
                       input int delay, input int kind, input int abort_idx);
        int cyc, wait_left, tidx, rd_idx, last_ack;
        bit seen, hang_now, err_now, fin;
        model(lanes, rate, tps3, intv);
        if (kind != 0) begin
            while (e_we.size() > abort_idx + 1) begin
                void'(e_we.pop_back()); void'(e_addr.pop_back()); void'(e_len.pop_back());
                void'(e_data.pop_back()); void'(e_wait.pop_back()); void'(e_tag.pop_back());
            end
            exp_code = 3;
        end
        @(negedge clk);
        lane_cfg = 3'(lanes); link_rate = 8'(rate); tps3_ok = tps3[0]; interval_cycles = 16'(intv);
        start = 1'b1;
        cyc = 0; seen = 0; tidx = 0; rd_idx = 0; last_ack = 0; fin = 0;
        hang_now = 0; err_now = 0; wait_left = 0;
        while (!fin && cyc < 30000) begin
            @(negedge clk);
            cyc++;
            acc_ack = 1'b0; acc_err = 1'b0;
            start = (cyc == 4); // R11: a start while busy must change nothing
            if (done) begin
                fin = 1;
                chk(e_we.size() == 0, "R11", {name, " done before all accesses"}, e_we.size(), 0);
                chk(pass == (exp_code == 0), "R11", {name, " pass"}, int'(pass), int'(exp_code == 0));
                chk(int'(fail_code) == exp_code, (exp_code == 3) ? "R10" : (exp_code == 2) ? "R8" : "R7",
                    {name, " fail code"}, int'(fail_code), exp_code);
            end else if (acc_req) begin
                if (!seen) begin
                    seen = 1; wait_left = delay;
                    hang_now = (kind == 2) && (tidx == abort_idx);
                    err_now  = (kind == 1) && (tidx == abort_idx);
                    tidx++;
                    if (e_we.size() == 0) begin
                        chk(0, "R10", {name, " unexpected request addr"}, int'(acc_addr), 0);
                    end else begin
                        chk(acc_we == e_we[0] && int'(acc_addr) == e_addr[0] && int'(acc_len) == e_len[0],
                            e_tag[0], {name, " request addr"}, int'(acc_addr), e_addr[0]);
                        if (e_we[0])
                            chk(acc_wdata == e_data[0], e_tag[0], {name, " write data"},
                                int'(acc_wdata), int'(e_data[0]));
                        if (e_wait[0] > 0)
                            chk(cyc - last_ack >= e_wait[0], e_tag[0], {name, " wait before access"},
                                cyc - last_ack, e_wait[0]);
                        void'(e_we.pop_front()); void'(e_addr.pop_front()); void'(e_len.pop_front());
                        void'(e_data.pop_front()); void'(e_wait.pop_front()); void'(e_tag.pop_front());
                    end
                end
                if (!hang_now) begin
                    if (wait_left == 0) begin
                        if (err_now) acc_err = 1'b1;
                        else acc_ack = 1'b1;
                        if (!acc_we) begin
                            acc_rdata = stat_at(rd_idx);
                            rd_idx++;
                        end
                        seen = 0; last_ack = cyc;
                    end else begin
                        wait_left--;
                    end
                end
            end
        end
        chk(fin, "R11", {name, " no done seen"}, 0, 1);
        acc_ack = 1'b0; acc_err = 1'b0; start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!acc_req && !done && !busy, "R10", {name, " quiet after done"}, int'(acc_req), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11 actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !acc_req, "R11", "reset state", int'({done, busy, acc_req}), 0);

        // R3 R4 R8: four lanes, both phases succeed at once, third pattern
        stat_in.delete();
        stat_in.push_back(mk(16'h1111, 0, 16'h0000));
        stat_in.push_back(mk(16'h7777, 1, 16'h0000));
        run("four_lane_pass", 4, 8'h0A, 1, 3, 0, 0, 0);

        // R5: two lanes, inactive lane requests ignored; R4 alignment missing once; R6 max pre-emphasis flag
        stat_in.delete();
        stat_in.push_back(mk(16'h0001, 0, 16'h0361));
        stat_in.push_back(mk(16'h0011, 0, 16'h0361));
        stat_in.push_back(mk(16'h0077, 0, 16'h000C));
        stat_in.push_back(mk(16'h0077, 1, 16'h0000));
        run("two_lane_adjust", 2, 8'h14, 0, 2, 1, 0, 0);

        // R3 R7: one lane, inactive lane bit set, illegal pair skipped (R6), stall counter restarts
        stat_in.delete();
        stat_in.push_back(mk(16'h0010, 0, 16'h000D));
        run("one_lane_stall", 1, 8'h06, 0, 1, 2, 0, 0);

        // R7: swing reaches its maximum, R6 swing max flag
        stat_in.delete();
        stat_in.push_back(mk(16'h0000, 0, 16'h0003));
        run("swing_max", 4, 8'h0A, 1, 2, 0, 0, 0);

        // R8: equalization never completes, lane 2 short one bit
        stat_in.delete();
        stat_in.push_back(mk(16'h1111, 0, 16'h0000));
        stat_in.push_back(mk(16'h7377, 1, 16'h0000));
        run("eq_fail", 4, 8'h0A, 0, 1, 0, 0, 0);

        // R10: error response on the power write
        stat_in.delete();
        run("access_error", 4, 8'h0A, 0, 2, 1, 1, 2);

        // R10: no answer to the phase 1 pattern write
        stat_in.delete();
        run("access_timeout", 2, 8'h0A, 1, 1, 0, 2, 4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule